// File: doc/BRIEF.md
# Address-Space-Tagged TLB with User-Adjustable Protection

This block is a small fully associative translation buffer. Each slot maps a virtual page of one address space to a physical frame and carries read and write rights, a page-valid flag and a privilege bit that only the kernel can set. A lookup is purely combinational. It compares the virtual page number and the current address-space ID against every slot and returns hit, miss, protection fault and the physical frame in the same cycle.

Two write paths change the slots. The kernel path writes every field of one slot, which it names by index. The user path names a page by its virtual page number and rewrites only that page's read and write rights. The user write takes effect only when the page belongs to the running address space and its slot carries the privilege bit. Any other user write is dropped and sets a sticky error flag. An optional amplify mode opens a faulting page to both reads and writes, so that the next access to it passes.

Top module: `prot_tlb`

## Requirements
- R1: After reset no slot holds a mapping. Every lookup reports a miss, and `err_o` is 0.
- R2: A kernel write to slot index k loads all fields of that slot. From the next cycle, a lookup with the same virtual page and `cur_asid_i` equal to the loaded ID reports a hit and returns the loaded frame.
- R3: A lookup whose virtual page or address-space ID matches no loaded slot reports a miss. It reports no hit and no fault, and the frame output is 0.
- R4: On a hit, a fault is reported when the page-valid flag is 0, when a store (`lk_store_i`=1) finds the write right at 0, or when a load (`lk_store_i`=0) finds the read right at 0. With `lk_valid_i` low, hit, miss and fault are all 0.
- R5: A user write that matches a slot of the current address space whose privilege bit is 1 replaces that slot's read and write rights from the next cycle. The frame, the tags and the other flags stay unchanged.
- R6: A user write that matches no slot under the current ID, or that matches a slot whose privilege bit is 0, leaves every slot unchanged and sets `err_o` from the next cycle. `err_o` holds until a cycle with `err_clr_i`=1 and no new error. A new error in the same cycle as a clear leaves `err_o` at 1.
- R7: With `amplify_en_i`=1, a fault on a slot whose page-valid flag is 1 is still reported in that cycle, and from the next cycle the slot grants both read and write. With `amplify_en_i`=0 a fault changes no state. A slot whose page-valid flag is 0 is never amplified.
- R8: When a kernel write and a user write hit the same slot in one cycle, the kernel write's fields win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_asid_i | input | 6 | Address-space ID of the running process |
| amplify_en_i | input | 1 | Grant access on a protection fault |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_store_i | input | 1 | 1 = store access, 0 = load |
| lk_hit_o | output | 1 | Lookup matched a slot |
| lk_miss_o | output | 1 | Lookup matched no slot |
| lk_fault_o | output | 1 | Protection fault on a matched slot |
| lk_pfn_o | output | 20 | Physical frame of the hit, 0 otherwise |
| kw_en_i | input | 1 | Kernel slot write |
| kw_idx_i | input | 4 | Slot index for the kernel write |
| kw_live_i | input | 1 | Slot holds a mapping |
| kw_vld_i | input | 1 | Page-valid flag |
| kw_vpn_i | input | 20 | Virtual page tag |
| kw_asid_i | input | 6 | Address-space tag |
| kw_pfn_i | input | 20 | Physical frame |
| kw_rd_i | input | 1 | Read right |
| kw_wr_i | input | 1 | Write right |
| kw_uperm_i | input | 1 | User may change rights on this slot |
| uw_en_i | input | 1 | User rights write |
| uw_vpn_i | input | 20 | Virtual page targeted by the user write |
| uw_rd_i | input | 1 | New read right |
| uw_wr_i | input | 1 | New write right |
| err_clr_i | input | 1 | Clear the sticky error flag |
| err_o | output | 1 | Sticky flag for a rejected user write |

## Verification
The assertions assume that the kernel never loads two live slots with the same page and ID. Under that assumption a lookup or user write matches at most one slot. The bench loads sixteen distinct pages, so that assumption always holds. The assertions also assume that `lk_valid_i` is held for exactly one clock per lookup, so amplification fires once. The bench drives each lookup for a single edge, and it never issues a user write in the same cycle as a lookup unless a case calls for both.

// File: rtl/prot_tlb_pkg.sv
package prot_tlb_pkg;
  parameter int VPN_W  = 20;
  parameter int PFN_W  = 20;
  parameter int ASID_W = 6;

  typedef struct packed {
    logic              live;
    logic              vld;
    logic              uperm;
    logic              rd;
    logic              wr;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } tlb_ent_t;
endpackage

// File: rtl/prot_tlb_cam.sv
module prot_tlb_cam
  import prot_tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tlb_ent_t [N-1:0]    ents_i,
  input  logic [VPN_W-1:0]    vpn_i,
  input  logic [ASID_W-1:0]   asid_i,
  output logic [N-1:0]        match_o,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = ents_i[i].live && ents_i[i].vpn == vpn_i && ents_i[i].asid == asid_i;
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match_o[i]) idx_o = IDX_W'(i);
  end

  // kernel keeps (vpn, asid) pairs unique: R2
  p_unique_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(match_o));
endmodule

// File: rtl/prot_tlb_slot.sv
module prot_tlb_slot
  import prot_tlb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     kw_sel_i,
  input  tlb_ent_t kw_ent_i,
  input  logic     uw_sel_i,
  input  logic     uw_rd_i,
  input  logic     uw_wr_i,
  input  logic     amp_sel_i,
  output tlb_ent_t ent_o
);
  tlb_ent_t ent_q;

  // priority: kernel > user > amplify
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (kw_sel_i) begin
      ent_q <= kw_ent_i;
    end else if (uw_sel_i) begin
      ent_q.rd <= uw_rd_i;
      ent_q.wr <= uw_wr_i;
    end else if (amp_sel_i) begin
      ent_q.rd <= 1'b1;
      ent_q.wr <= 1'b1;
    end
  end

  assign ent_o = ent_q;

  p_kernel_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kw_sel_i |=> ent_q == $past(kw_ent_i));

  p_user_keeps_xlat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uw_sel_i && !kw_sel_i |=> $stable(ent_q.pfn) && $stable(ent_q.vpn) && $stable(ent_q.asid)
                               && $stable(ent_q.vld) && $stable(ent_q.uperm) && $stable(ent_q.live));

  p_amplify_grants_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_sel_i && !kw_sel_i && !uw_sel_i |=> ent_q.rd && ent_q.wr);
endmodule

// File: rtl/prot_tlb.sv
module prot_tlb
  import prot_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              amplify_en_i,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic              lk_store_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  input  logic              kw_en_i,
  input  logic [IDX_W-1:0]  kw_idx_i,
  input  logic              kw_live_i,
  input  logic              kw_vld_i,
  input  logic [VPN_W-1:0]  kw_vpn_i,
  input  logic [ASID_W-1:0] kw_asid_i,
  input  logic [PFN_W-1:0]  kw_pfn_i,
  input  logic              kw_rd_i,
  input  logic              kw_wr_i,
  input  logic              kw_uperm_i,
  input  logic              uw_en_i,
  input  logic [VPN_W-1:0]  uw_vpn_i,
  input  logic              uw_rd_i,
  input  logic              uw_wr_i,
  input  logic              err_clr_i,
  output logic              err_o
);
  tlb_ent_t [NUM_ENTRIES-1:0] ents;
  tlb_ent_t                   kw_ent, lk_ent, uw_ent;
  logic [NUM_ENTRIES-1:0]     lk_match, uw_match;
  logic                       lk_any, uw_any, perm_bad, uw_ok, uw_bad, err_q;
  logic [IDX_W-1:0]           lk_idx, uw_idx;

  prot_tlb_cam #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_cam (
    .clk_i, .rst_ni, .ents_i(ents), .vpn_i(lk_vpn_i), .asid_i(cur_asid_i),
    .match_o(lk_match), .hit_o(lk_any), .idx_o(lk_idx));

  prot_tlb_cam #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_uw_cam (
    .clk_i, .rst_ni, .ents_i(ents), .vpn_i(uw_vpn_i), .asid_i(cur_asid_i),
    .match_o(uw_match), .hit_o(uw_any), .idx_o(uw_idx));

  assign lk_ent = ents[lk_idx];
  assign uw_ent = ents[uw_idx];

  always_comb begin
    kw_ent       = '0;
    kw_ent.live  = kw_live_i;
    kw_ent.vld   = kw_vld_i;
    kw_ent.uperm = kw_uperm_i;
    kw_ent.rd    = kw_rd_i;
    kw_ent.wr    = kw_wr_i;
    kw_ent.asid  = kw_asid_i;
    kw_ent.vpn   = kw_vpn_i;
    kw_ent.pfn   = kw_pfn_i;
  end

  assign perm_bad   = !lk_ent.vld || (lk_store_i ? !lk_ent.wr : !lk_ent.rd);
  assign lk_hit_o   = lk_valid_i && lk_any;
  assign lk_miss_o  = lk_valid_i && !lk_any;
  assign lk_fault_o = lk_hit_o && perm_bad;
  assign lk_pfn_o   = lk_hit_o ? lk_ent.pfn : '0;

  assign uw_ok  = uw_en_i && uw_any && uw_ent.uperm;
  assign uw_bad = uw_en_i && !uw_ok;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic kw_sel, uw_sel, amp_sel;
    assign kw_sel  = kw_en_i && kw_idx_i == IDX_W'(i);
    assign uw_sel  = uw_ok && uw_match[i];
    assign amp_sel = amplify_en_i && lk_fault_o && lk_match[i] && ents[i].vld;
    prot_tlb_slot u_slot (
      .clk_i, .rst_ni, .kw_sel_i(kw_sel), .kw_ent_i(kw_ent), .uw_sel_i(uw_sel),
      .uw_rd_i, .uw_wr_i, .amp_sel_i(amp_sel), .ent_o(ents[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (uw_bad)    err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end
  assign err_o = err_q;

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o);

  p_fault_needs_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o && !lk_miss_o);
endmodule

// File: tb/prot_tlb_test.sv
module prot_tlb_test;
  import prot_tlb_pkg::*;
  localparam int N = 16;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [ASID_W-1:0] cur_asid = '0;
  logic amp_en = 0, lk_valid = 0, lk_store = 0;
  logic [VPN_W-1:0] lk_vpn = '0, kw_vpn = '0, uw_vpn = '0;
  logic lk_hit, lk_miss, lk_fault, err;
  logic [PFN_W-1:0] lk_pfn, kw_pfn = '0;
  logic kw_en = 0, kw_live = 0, kw_vld = 0, kw_rd = 0, kw_wr = 0, kw_up = 0;
  logic [3:0] kw_idx = '0;
  logic [ASID_W-1:0] kw_asid = '0;
  logic uw_en = 0, uw_rd = 0, uw_wr = 0, err_clr = 0;

  prot_tlb uut (
    .clk_i(clk), .rst_ni(rst_n), .cur_asid_i(cur_asid), .amplify_en_i(amp_en),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_store_i(lk_store),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault), .lk_pfn_o(lk_pfn),
    .kw_en_i(kw_en), .kw_idx_i(kw_idx), .kw_live_i(kw_live), .kw_vld_i(kw_vld),
    .kw_vpn_i(kw_vpn), .kw_asid_i(kw_asid), .kw_pfn_i(kw_pfn), .kw_rd_i(kw_rd),
    .kw_wr_i(kw_wr), .kw_uperm_i(kw_up), .uw_en_i(uw_en), .uw_vpn_i(uw_vpn),
    .uw_rd_i(uw_rd), .uw_wr_i(uw_wr), .err_clr_i(err_clr), .err_o(err));

  int n_vec = 0, n_bad = 0;
  bit m_live[N], m_vld[N], m_rd[N], m_wr[N], m_up[N];
  int m_vpn[N], m_asid[N], m_pfn[N];

  function automatic int vpn_of(int i);  return 'h100 + i * 3; endfunction
  function automatic int asid_of(int i); return i % 3 + 1; endfunction
  function automatic int pfn_of(int i);  return 'hA000 ^ (i * 17); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic kload(int i, bit live, bit vld, int vpn, int asid, int pfn, bit rd, bit wr, bit up);
    kw_en = 1; kw_idx = 4'(i); kw_live = live; kw_vld = vld; kw_vpn = VPN_W'(vpn);
    kw_asid = ASID_W'(asid); kw_pfn = PFN_W'(pfn); kw_rd = rd; kw_wr = wr; kw_up = up;
    cyc; kw_en = 0;
    m_live[i] = live; m_vld[i] = vld; m_vpn[i] = vpn; m_asid[i] = asid;
    m_pfn[i] = pfn; m_rd[i] = rd; m_wr[i] = wr; m_up[i] = up;
  endtask

  function automatic int find(int vpn, int asid);
    for (int j = 0; j < N; j++)
      if (m_live[j] && m_vpn[j] == vpn && m_asid[j] == asid) return j;
    return -1;
  endfunction

  // one-cycle lookup; updates the model when amplification applies
  task automatic look(string req, int vpn, int asid, bit st);
    int j; bit eh, ef; int ep;
    cur_asid = ASID_W'(asid); lk_vpn = VPN_W'(vpn); lk_store = st; lk_valid = 1;
    j = find(vpn, asid);
    eh = (j >= 0);
    ef = eh && (!m_vld[j] || (st ? !m_wr[j] : !m_rd[j]));
    ep = eh ? m_pfn[j] : 0;
    #2;
    chk({req, " hit"}, 32'(lk_hit), 32'(eh));
    chk({req, " miss"}, 32'(lk_miss), 32'(!eh));
    chk({req, " fault"}, 32'(lk_fault), 32'(ef));
    chk({req, " pfn"}, 32'(lk_pfn), 32'(ep));
    @(posedge clk); @(negedge clk);
    lk_valid = 0;
    if (amp_en && ef && m_vld[j]) begin m_rd[j] = 1; m_wr[j] = 1; end
  endtask

  task automatic uwrite(string req, int vpn, int asid, bit rd, bit wr);
    int j; bit ok;
    cur_asid = ASID_W'(asid); uw_vpn = VPN_W'(vpn); uw_rd = rd; uw_wr = wr; uw_en = 1;
    j = find(vpn, asid);
    ok = (j >= 0) && m_up[j];
    cyc; uw_en = 0;
    if (ok) begin m_rd[j] = rd; m_wr[j] = wr; end
    chk({req, " err"}, 32'(err), 32'(!ok));
    err_clr = 1; cyc; err_clr = 0;
    chk("R6 err cleared", 32'(err), 0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_live[i] = 0; m_vld[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_up[i] = 0;
      m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    chk("R1 err", 32'(err), 0);
    for (int i = 0; i < N; i++) look("R1 reset", vpn_of(i), asid_of(i), 0);
    look("R1 reset zero", 0, 0, 0);

    // R2: load all slots; slots 3 and 10 carry page-valid 0
    for (int i = 0; i < N; i++)
      kload(i, 1, (i % 7) != 3, vpn_of(i), asid_of(i), pfn_of(i), i[0], i[1], i[2]);

    // R2 R3 R4: every slot against every ID and both access kinds
    for (int i = 0; i < N; i++)
      for (int a = 0; a < 4; a++)
        for (int s = 0; s < 2; s++)
          look("R2 R3 R4 sweep", vpn_of(i), a, s[0]);
    look("R3 unmapped", 'h50, 1, 0);
    look("R3 unmapped", 'hFFFFF, 2, 1);

    // R4: idle lookup reports nothing
    lk_valid = 0; lk_vpn = VPN_W'(vpn_of(1)); cur_asid = ASID_W'(asid_of(1)); #2;
    chk("R4 idle hit", 32'(lk_hit), 0);
    chk("R4 idle miss", 32'(lk_miss), 0);
    chk("R4 idle fault", 32'(lk_fault), 0);
    @(negedge clk);

    // R5 R6: user writes invert rights on every slot
    for (int i = 0; i < N; i++) begin
      uwrite("R5 R6 user", vpn_of(i), asid_of(i), !m_rd[i], !m_wr[i]);
      look("R5 after user ld", vpn_of(i), asid_of(i), 0);
      look("R5 after user st", vpn_of(i), asid_of(i), 1);
    end

    // R6: permitted slot under a foreign ID is rejected and unchanged
    uwrite("R6 foreign id", vpn_of(4), asid_of(4) % 3 + 1, 1, 1);
    look("R6 unchanged ld", vpn_of(4), asid_of(4), 0);
    look("R6 unchanged st", vpn_of(4), asid_of(4), 1);
    uwrite("R6 unmapped", 'h77, 1, 1, 1);

    // R6: a new error wins over a clear in the same cycle
    uw_en = 1; uw_vpn = VPN_W'(vpn_of(0)); cur_asid = ASID_W'(asid_of(0)); err_clr = 1;
    cyc; uw_en = 0; err_clr = 0;
    chk("R6 set beats clear", 32'(err), 1);
    cyc;
    chk("R6 sticky", 32'(err), 1);
    err_clr = 1; cyc; err_clr = 0;
    chk("R6 cleared", 32'(err), 0);

    // R8: kernel and user write to slot 5 in one cycle
    kw_en = 1; kw_idx = 4'd5; kw_live = 1; kw_vld = 1; kw_vpn = VPN_W'(vpn_of(5));
    kw_asid = ASID_W'(asid_of(5)); kw_pfn = PFN_W'('h1234); kw_rd = 1; kw_wr = 0; kw_up = 1;
    uw_en = 1; uw_vpn = VPN_W'(vpn_of(5)); cur_asid = ASID_W'(asid_of(5)); uw_rd = 0; uw_wr = 1;
    cyc; kw_en = 0; uw_en = 0;
    m_pfn[5] = 'h1234; m_rd[5] = 1; m_wr[5] = 0; m_vld[5] = 1; m_up[5] = 1;
    chk("R8 no err", 32'(err), 0);
    look("R8 kernel wins ld", vpn_of(5), asid_of(5), 0);
    look("R8 kernel wins st", vpn_of(5), asid_of(5), 1);

    // R7: with amplify off a repeated fault stays a fault
    look("R7 off first", vpn_of(5), asid_of(5), 1);
    look("R7 off again", vpn_of(5), asid_of(5), 1);

    // R7: amplify on; fault reported once, then both rights granted
    amp_en = 1;
    for (int i = 0; i < N; i++) begin
      look("R7 amp store", vpn_of(i), asid_of(i), 1);
      look("R7 amp after st", vpn_of(i), asid_of(i), 1);
      look("R7 amp after ld", vpn_of(i), asid_of(i), 0);
    end
    amp_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule